// File: doc/BRIEF.md
# Byte-Stream Bootstrap Word Loader

This block does in hardware what a tiny boot program would otherwise do in software. After a start pulse it takes bytes from a byte source over a valid/ready handshake and throws them all away until a start marker byte of value 2 arrives. The marker itself is dropped. From then on the bytes are paired into 16-bit words, most significant byte first. Each word goes out on a simple memory write port to consecutive addresses, starting at a fixed load base.

Once a fixed number of words has been written, the block issues a one-cycle start request that carries the load base as the jump address. It then goes back to idle. The profile is chosen by a mode input that is sampled at the start pulse. The paper-tape profile loads 64 words at octal 03700, and the source must show not-valid between bytes. The terminal profile loads 62 words at octal 037700, and it first pulses a receive-flag clear.

Top module: `boot_word_loader`

## Requirements
- R1: After reset the block is idle: byteReady, memWrEn, runReq and rxClear are all low.
- R2: On a start pulse in terminal mode (termMode=1), rxClear is high for exactly the one cycle after the pulse, and no byte is accepted in that cycle. In paper-tape mode (termMode=0), rxClear stays low and byte acceptance begins in the cycle after the pulse.
- R3: Every byte accepted before the first byte equal to 2 is discarded. The marker byte is not stored either. After the marker, a byte of value 2 is ordinary data.
- R4: Each stored word has the first byte of a pair in bits 15:8 and the second byte in bits 7:0.
- R5: The write pointer is preset to one below the load base and incremented before each store. The first word therefore lands at octal 03700 in paper-tape mode and at octal 037700 in terminal mode, and each later word lands at the next address.
- R6: Exactly 64 words are written in paper-tape mode and exactly 62 in terminal mode.
- R7: After the last write completes, runReq is high for exactly one cycle, with runAddr equal to the load base of the mode.
- R8: In paper-tape mode, once a byte has been accepted, byteReady stays low until byteValid has been seen low at a clock edge. A byte held on the port is therefore never taken twice. Terminal mode has no such gap.
- R9: memWrEn stays high, with memAddr and memData stable, until memWrReady is high at a clock edge. While a write is pending, byteReady is low, so no byte is lost.
- R10: After the start request the block stays idle until a new start pulse. Bytes offered while idle are not accepted and cause no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Begins a load; sampled only while idle |
| termMode | input | 1 | Profile select sampled at start: 1 = terminal, 0 = paper tape |
| byteValid | input | 1 | Byte source has a byte |
| byteData | input | 8 | Byte from the source |
| byteReady | output | 1 | Loader accepts byteData at this edge when byteValid is high |
| rxClear | output | 1 | One-cycle receive-flag clear in terminal mode |
| memWrEn | output | 1 | Write request |
| memAddr | output | 16 | Write address |
| memData | output | 16 | Write data |
| memWrReady | input | 1 | Memory takes the write at this edge |
| runReq | output | 1 | One-cycle start request to the processor |
| runAddr | output | 16 | Jump address accompanying runReq |

## Verification
Both profiles are loaded with data patterns that contain the value 2 in the low byte of the first word. This tells marker detection apart from treating later 2s as data. Runs are led by garbage bytes of 0, 1, 3 and 0xFF, which shows that any non-marker value is dropped. One run uses a memory that accepts writes only every third cycle, which separates correct back-pressure from dropped bytes. Holding a byte on the port shows the paper-tape re-read guard against the terminal profile, which takes bytes back to back. Offering bytes after completion shows that the block stays idle.

// File: rtl/bwl_pkg.sv
package bwl_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_CLEAR, S_HUNT, S_HIGH, S_LOW, S_STORE, S_LAUNCH
  } ldState_t;

  typedef struct packed {
    logic armLoad;   // preset pointer/counter for the selected profile
    logic takeHigh;  // capture upper byte
    logic takeLow;   // capture lower byte and pre-increment pointer
    logic wordDone;  // a write has been accepted by memory
  } dpStrobe_t;
endpackage

// File: rtl/bwl_datapath.sv
module bwl_datapath
  import bwl_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int TAPE_BASE  = 'o3700,
  parameter int TERM_BASE  = 'o37700,
  parameter int TAPE_WORDS = 64,
  parameter int TERM_WORDS = 62
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              termSel,
  input  logic [7:0]        byteData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [15:0]       memData,
  output logic [ADDR_W-1:0] runAddr,
  output logic              lastWord
);
  localparam int MAX_WORDS = (TAPE_WORDS > TERM_WORDS) ? TAPE_WORDS : TERM_WORDS;
  localparam int CNT_W     = $clog2(MAX_WORDS + 1);

  logic [ADDR_W-1:0] ptr, baseR;
  logic [CNT_W-1:0]  cnt, limitR;
  logic [7:0]        hiByte, loByte;
  logic [ADDR_W-1:0] selBase;
  logic [CNT_W-1:0]  selLimit;

  always_comb begin
    selBase  = termSel ? ADDR_W'(TERM_BASE) : ADDR_W'(TAPE_BASE);
    selLimit = termSel ? CNT_W'(TERM_WORDS) : CNT_W'(TAPE_WORDS);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr    <= '0;
      baseR  <= '0;
      cnt    <= '0;
      limitR <= '0;
      hiByte <= '0;
      loByte <= '0;
    end else begin
      if (strobe.armLoad) begin
        ptr    <= selBase - 1'b1;
        baseR  <= selBase;
        cnt    <= '0;
        limitR <= selLimit;
      end
      if (strobe.takeHigh) hiByte <= byteData;
      if (strobe.takeLow) begin
        loByte <= byteData;
        ptr    <= ptr + 1'b1;
      end
      if (strobe.wordDone) cnt <= cnt + 1'b1;
    end
  end

  assign memAddr  = ptr;
  assign memData  = {hiByte, loByte};
  assign runAddr  = baseR;
  assign lastWord = (cnt == limitR - 1'b1);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= limitR) else $error("word counter passed its limit"); // R6
endmodule

// File: rtl/bwl_ctrl.sv
module bwl_ctrl
  import bwl_pkg::*;
#(
  parameter logic [7:0] MARKER = 8'd2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       termMode,
  input  logic       byteValid,
  input  logic [7:0] byteData,
  output logic       byteReady,
  output logic       rxClear,
  output logic       memWrEn,
  input  logic       memWrReady,
  input  logic       lastWord,
  output logic       runReq,
  output logic       termSel,
  output dpStrobe_t  strobe
);
  ldState_t st, stNext;
  logic modeTerm, waitLow;
  logic takeByte, inTake;

  assign inTake    = (st == S_HUNT) || (st == S_HIGH) || (st == S_LOW);
  assign byteReady = inTake && !(waitLow && !modeTerm);
  assign takeByte  = byteReady && byteValid;
  assign rxClear   = (st == S_CLEAR);
  assign memWrEn   = (st == S_STORE);
  assign runReq    = (st == S_LAUNCH);
  assign termSel   = (st == S_IDLE) ? termMode : modeTerm;

  always_comb begin
    stNext          = st;
    strobe          = '0;
    strobe.armLoad  = (st == S_IDLE) && startPulse;
    strobe.takeHigh = (st == S_HIGH) && takeByte;
    strobe.takeLow  = (st == S_LOW) && takeByte;
    strobe.wordDone = (st == S_STORE) && memWrReady;
    unique case (st)
      S_IDLE:   if (startPulse) stNext = termMode ? S_CLEAR : S_HUNT;
      S_CLEAR:  stNext = S_HUNT;
      S_HUNT:   if (takeByte && byteData == MARKER) stNext = S_HIGH;
      S_HIGH:   if (takeByte) stNext = S_LOW;
      S_LOW:    if (takeByte) stNext = S_STORE;
      S_STORE:  if (memWrReady) stNext = lastWord ? S_LAUNCH : S_HIGH;
      S_LAUNCH: stNext = S_IDLE;
      default:  stNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st       <= S_IDLE;
      modeTerm <= 1'b0;
      waitLow  <= 1'b0;
    end else begin
      st <= stNext;
      if (st == S_IDLE && startPulse) begin
        modeTerm <= termMode;
        waitLow  <= 1'b0;
      end else if (takeByte) begin
        waitLow <= 1'b1;
      end else if (!byteValid) begin
        waitLow <= 1'b0;
      end
    end
  end

  AST_TAPE_NO_REREAD: assert property (@(posedge clk) disable iff (!rstN)
    (takeByte && !modeTerm && st != S_LOW) |=> !byteReady) else $error("tape byte re-read"); // R8
  AST_NO_TAKE_WHILE_WRITING: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> !byteReady) else $error("byte taken during write"); // R9
  AST_WRITE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && !memWrReady) |=> memWrEn) else $error("write dropped"); // R9
  AST_RUN_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    runReq |=> !runReq && !byteReady) else $error("start request not single"); // R7
  AST_CLEAR_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rxClear |=> !rxClear) else $error("flag clear too long"); // R2
endmodule

// File: rtl/boot_word_loader.sv
module boot_word_loader
  import bwl_pkg::*;
#(
  parameter int         ADDR_W     = 16,
  parameter int         TAPE_BASE  = 'o3700,
  parameter int         TERM_BASE  = 'o37700,
  parameter int         TAPE_WORDS = 64,
  parameter int         TERM_WORDS = 62,
  parameter logic [7:0] MARKER     = 8'd2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic              termMode,
  input  logic              byteValid,
  input  logic [7:0]        byteData,
  output logic              byteReady,
  output logic              rxClear,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [15:0]       memData,
  input  logic              memWrReady,
  output logic              runReq,
  output logic [ADDR_W-1:0] runAddr
);
  dpStrobe_t strobe;
  logic      termSel, lastWord;

  bwl_ctrl #(.MARKER(MARKER)) uCtrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .termMode(termMode),
    .byteValid(byteValid), .byteData(byteData), .byteReady(byteReady),
    .rxClear(rxClear), .memWrEn(memWrEn), .memWrReady(memWrReady),
    .lastWord(lastWord), .runReq(runReq), .termSel(termSel), .strobe(strobe)
  );

  bwl_datapath #(
    .ADDR_W(ADDR_W), .TAPE_BASE(TAPE_BASE), .TERM_BASE(TERM_BASE),
    .TAPE_WORDS(TAPE_WORDS), .TERM_WORDS(TERM_WORDS)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .termSel(termSel),
    .byteData(byteData), .memAddr(memAddr), .memData(memData),
    .runAddr(runAddr), .lastWord(lastWord)
  );

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && !memWrReady) |=> $stable(memAddr) && $stable(memData)) else $error("pending write changed"); // R9
endmodule

// File: tb/sim_boot_word_loader.sv
`timescale 1ns/1ps
module sim_boot_word_loader;
  logic clk = 0, rstN = 0;
  logic startPulse = 0, termMode = 0, byteValid = 0, memWrReady = 1;
  logic [7:0] byteData = 0;
  logic byteReady, rxClear, memWrEn, runReq;
  logic [15:0] memAddr, memData, runAddr;

  int nChk = 0, nFail = 0;
  int wrN = 0, cyc = 0, overlapBad = 0;
  logic stallOn = 0;
  logic [15:0] wrAddr [0:127];
  logic [15:0] wrData [0:127];

  always #4 clk = ~clk;

  boot_word_loader u0 (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (memWrEn && byteReady) overlapBad <= overlapBad + 1;
    if (memWrEn && memWrReady) begin
      if (wrN < 128) begin
        wrAddr[wrN] <= memAddr;
        wrData[wrN] <= memData;
      end
      wrN <= wrN + 1;
    end
  end
  always @(negedge clk) memWrReady <= stallOn ? (cyc % 3 == 0) : 1'b1;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    byteValid = 1; byteData = b;
    while (!byteReady) @(negedge clk);
    @(negedge clk);
    byteValid = 0;
    @(negedge clk);
  endtask

  function automatic logic [15:0] patWord(int i, int seed);
    return {8'(i * 3 + seed), 8'(8'd2 ^ 8'(i))};
  endfunction

  task automatic pulseStart(input logic term);
    termMode = term; startPulse = 1;
    @(negedge clk);
    startPulse = 0;
  endtask

  task automatic runLoad(input logic term, input int garbage, input int seed, input logic stall);
    int words = term ? 62 : 64;
    logic [15:0] base = term ? 16'o37700 : 16'o3700;
    int t;
    bit seenRun;
    bit badData;
    stallOn = stall;
    wrN = 0;
    pulseStart(term);
    check(term ? "R2 clear pulse" : "R2 no clear", rxClear, term);
    check("R2 ready", byteReady, !term);
    for (int g = 0; g < garbage; g++) begin
      logic [7:0] junk = (g % 4 == 0) ? 8'h00 : (g % 4 == 1) ? 8'h01 : (g % 4 == 2) ? 8'h03 : 8'hFF;
      sendByte(junk);
    end
    check("R3 nothing stored before marker", wrN, 0);
    sendByte(8'd2);
    for (int i = 0; i < words; i++) begin
      logic [15:0] w = patWord(i, seed);
      sendByte(w[15:8]);
      sendByte(w[7:0]);
    end
    seenRun = 0;
    t = 0;
    while (!seenRun && t < 50) begin
      if (runReq) begin
        seenRun = 1;
        check("R7 run address", runAddr, base);
        @(negedge clk);
        check("R7 single cycle", runReq, 0);
      end else begin
        @(negedge clk);
      end
      t++;
    end
    check("R7 run request seen", seenRun, 1);
    check("R6 word count", wrN, words);
    check("R5 first address", wrAddr[0], base);
    check("R5 last address", wrAddr[words - 1], base + 16'(words - 1));
    badData = 0;
    for (int i = 0; i < words; i++)
      if (wrAddr[i] !== base + 16'(i) || wrData[i] !== patWord(i, seed)) badData = 1;
    check("R4 R5 all words", badData, 0);
    check("R3 marker-after 2 is data", wrData[0][7:0], 8'd2);
    check("R9 no take during write", overlapBad, 0);
    stallOn = 0;
  endtask

  task automatic holdTest(input logic term);
    bit anyReady;
    pulseStart(term);
    if (term) @(negedge clk);
    sendByte(8'd2);
    byteValid = 1; byteData = 8'h55;
    while (!byteReady) @(negedge clk);
    @(negedge clk);
    anyReady = 0;
    for (int k = 0; k < 4; k++) begin
      if (byteReady) anyReady = 1;
      @(negedge clk);
    end
    check(term ? "R8 term no gap" : "R8 tape gap", anyReady, term);
    byteValid = 0;
    @(negedge clk);
    rstN = 0;
    @(negedge clk);
    rstN = 1;
    @(negedge clk);
  endtask

  task automatic idleTest();
    int w0 = wrN;
    bit anyReady = 0;
    byteValid = 1; byteData = 8'd2;
    for (int k = 0; k < 6; k++) begin
      if (byteReady) anyReady = 1;
      @(negedge clk);
    end
    byteValid = 0;
    check("R10 idle not ready", anyReady, 0);
    check("R10 idle no write", wrN, w0);
  endtask

  initial begin
    #1500000;
    nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ready", byteReady, 0);
    check("R1 write", memWrEn, 0);
    check("R1 run", runReq, 0);
    check("R1 clear", rxClear, 0);
    rstN = 1;
    @(negedge clk);
    runLoad(0, 5, 7, 0);
    idleTest();
    runLoad(1, 8, 40, 0);
    runLoad(0, 2, 11, 1);
    holdTest(0);
    holdTest(1);
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end
endmodule